// File: doc/BRIEF.md
# Multiprocessor Serial Transmitter with FIFO

This block turns bytes queued in a 16-entry FIFO into asynchronous serial frames on a single transmit line. The frame format is set at run time. Each frame has a start bit and 1 to 8 data bits sent least-significant first. An address bit follows the data when address marking is selected, then an optional odd or even parity bit, then one or two stop bits. A bit-period tick from outside paces every line transition, so the block has no baud divider of its own.

Several nodes can share one line, and a transmitter must tell them where a new message starts. A wake request, taken as a single-cycle pulse, does this in one of two ways. In gap mode the next character goes out behind exactly 11 idle bit periods. In address-marking mode the address bit of the next frame is sent as one. The request is consumed when that character leaves the FIFO. A programmable delay of 0 to 255 bit periods can separate frames taken back to back from the FIFO.

The block reports the FIFO fill level, a ready flag (the FIFO has room) and an empty flag (the FIFO and the shifter are both empty). A level-match interrupt flag has a write-one clear and an enable gate.

Top module: `mptx_top`

## Requirements
- R1: The line idles high. A frame is a low start bit, then the data bits LSB first, then the address bit (address-marking mode only), then the parity bit (if enabled), then the stop bits (high). The line changes only on a cycle where bit_tick_i is high, and each bit lasts one tick period.
- R2: char_len_i gives the number of data bits as char_len_i + 1 (value 6 gives 7 bits).
- R3: With parity_en_i = 1, one parity bit is sent. Counted over the sent data bits plus the address bit (when present), the total number of ones including the parity bit is even when parity_even_i = 1 and odd when parity_even_i = 0. With parity_en_i = 0 no parity bit is sent.
- R4: two_stop_i = 1 sends two stop bits, and 0 sends one.
- R5: Gap mode is addr_mode_i = 0. A pulse on wake_set_i makes the next character loaded into the shifter go out behind exactly 11 high bit periods.
- R6: Address-marking mode is addr_mode_i = 1. The frame loaded after a wake_set_i pulse carries an address bit of 1, and all other frames carry 0. wake_pend_o is 1 from the cycle after the pulse until the cycle after that character is loaded, and then clears.
- R7: The FIFO holds 16 bytes. fifo_cnt_o reports 0 to 16. tx_ready_o is 0 only at 16. A write while full is ignored and leaves the stored bytes intact.
- R8: A fifo_rst_i pulse empties the FIFO (fifo_cnt_o = 0 on the next cycle). Bytes discarded this way are never sent.
- R9: int_flag_o sets in the cycle after fifo_cnt_o equals int_level_i. An int_clr_i pulse clears it on the next cycle. irq_o = int_flag_o AND int_en_i.
- R10: When the next byte is waiting, the line stays high for exactly delay_i bit periods between the last stop bit of one frame and the start bit of the next. A delay of 0 sends the frames back to back.
- R11: tx_empty_o is 1 exactly when the FIFO is empty and no frame or gap is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| wr_en_i | input | 1 | Push wr_data_i into the FIFO |
| wr_data_i | input | 8 | Character to queue |
| fifo_rst_i | input | 1 | Empty the FIFO |
| char_len_i | input | 3 | Data bits minus one |
| parity_en_i | input | 1 | Append a parity bit |
| parity_even_i | input | 1 | 1 even, 0 odd parity |
| two_stop_i | input | 1 | 1 two stop bits, 0 one |
| addr_mode_i | input | 1 | 1 address-marking, 0 gap wake mode |
| wake_set_i | input | 1 | Request wake marking for the next character |
| delay_i | input | 8 | Idle bit periods between FIFO frames |
| int_level_i | input | 5 | FIFO level that sets the interrupt flag |
| int_en_i | input | 1 | Interrupt enable |
| int_clr_i | input | 1 | Write-one clear of the interrupt flag |
| tx_o | output | 1 | Serial line |
| tx_ready_o | output | 1 | FIFO can accept a byte |
| tx_empty_o | output | 1 | FIFO and shifter both empty |
| fifo_cnt_o | output | 5 | Bytes held in the FIFO |
| int_flag_o | output | 1 | Level-match flag |
| irq_o | output | 1 | Gated interrupt |
| wake_pend_o | output | 1 | Wake request not yet consumed |

## Verification
The bound assertions check the following on every cycle. The line moves only on a tick. An empty block holds the line high. The FIFO count stays within 0 to 16 and moves by at most one per cycle. A full FIFO stays full with no tick, which shows that extra writes are dropped. A FIFO reset empties it, a clear drops the flag, and the interrupt never rises without its flag. The bench decodes the line bit by bit against frames it builds itself from the format inputs. Only these scenarios can show bit order, parity sense, stop count, the exact 11-period gap, the address bit landing on the right frame, the exact inter-frame delay, and that discarded or overflow bytes never reach the line.

// File: rtl/mptx_pkg.sv
package mptx_pkg;
  localparam int MAX_BITS = 8;
  localparam int LEN_W    = $clog2(MAX_BITS);

  typedef struct packed {
    logic [LEN_W-1:0] len_m1;
    logic             par_en;
    logic             par_even;
    logic             two_stop;
    logic             addr_mode;
  } frame_cfg_t;
endpackage

// File: rtl/mptx_fifo.sv
module mptx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_o == CNT_W'(DEPTH));
  assign empty_o = (cnt_o == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign data_o  = mem[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_o  <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_o  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      if (push_ok && !pop_ok)      cnt_o <= cnt_o + CNT_W'(1);
      else if (pop_ok && !push_ok) cnt_o <= cnt_o - CNT_W'(1);
    end
  end
endmodule

// File: rtl/mptx_serializer.sv
module mptx_serializer
  import mptx_pkg::*;
#(
  parameter int GAP_BITS = 11,
  parameter int DLY_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  frame_cfg_t          cfg_i,
  input  logic [DLY_W-1:0]    delay_i,
  input  logic                avail_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic                wake_i,
  output logic                pop_o,
  output logic                tx_o,
  output logic                busy_o
);
  // start + data + address + parity + 2 stop
  localparam int FRM_W = MAX_BITS + 5;
  localparam int VEC_W = FRM_W + GAP_BITS;
  localparam int CW    = $clog2(VEC_W + 1);

  logic [VEC_W-1:0] shreg, vec;
  logic [CW-1:0]    bit_cnt, vec_len;
  logic [DLY_W-1:0] dly_cnt;
  logic             last, load;

  // whole frame, gap included, assembled from the FIFO head
  always_comb begin
    logic [CW-1:0] idx;
    logic          par;
    vec = '1;
    par = !cfg_i.par_even;
    idx = (!cfg_i.addr_mode && wake_i) ? CW'(GAP_BITS) : '0;
    vec[idx] = 1'b0;
    idx = idx + CW'(1);
    for (int i = 0; i < MAX_BITS; i++) begin
      if (i <= int'(cfg_i.len_m1)) begin
        vec[idx] = data_i[i];
        par      = par ^ data_i[i];
        idx      = idx + CW'(1);
      end
    end
    if (cfg_i.addr_mode) begin
      vec[idx] = wake_i;
      par      = par ^ wake_i;
      idx      = idx + CW'(1);
    end
    if (cfg_i.par_en) begin
      vec[idx] = par;
      idx      = idx + CW'(1);
    end
    vec_len = idx + (cfg_i.two_stop ? CW'(2) : CW'(1));
  end

  assign busy_o = (bit_cnt != '0);
  assign last   = (bit_cnt == CW'(1));
  assign load   = tick_i && avail_i &&
                  (busy_o ? (last && delay_i == '0) : (dly_cnt <= DLY_W'(1)));
  assign pop_o  = load;
  assign tx_o   = busy_o ? shreg[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg   <= '1;
      bit_cnt <= '0;
      dly_cnt <= '0;
    end else if (tick_i) begin
      if (load) begin
        shreg   <= vec;
        bit_cnt <= vec_len;
        dly_cnt <= '0;
      end else if (busy_o) begin
        shreg   <= {1'b1, shreg[VEC_W-1:1]};
        bit_cnt <= bit_cnt - CW'(1);
        if (last) dly_cnt <= delay_i;
      end else if (dly_cnt != '0) begin
        dly_cnt <= dly_cnt - DLY_W'(1);
      end
    end
  end
endmodule

// File: rtl/mptx_lvl_irq.sv
module mptx_lvl_irq #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] level_i,
  input  logic             en_i,
  input  logic             clr_i,
  output logic             flag_o,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               flag_o <= 1'b0;
    else if (clr_i)            flag_o <= 1'b0;
    else if (cnt_i == level_i) flag_o <= 1'b1;
  end

  assign irq_o = flag_o && en_i;
endmodule

// File: rtl/mptx_top.sv
module mptx_top
  import mptx_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int GAP_BITS = 11,
  parameter int DLY_W    = 8,
  parameter int CNT_W    = $clog2(DEPTH+1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_tick_i,
  input  logic                wr_en_i,
  input  logic [MAX_BITS-1:0] wr_data_i,
  input  logic                fifo_rst_i,
  input  logic [LEN_W-1:0]    char_len_i,
  input  logic                parity_en_i,
  input  logic                parity_even_i,
  input  logic                two_stop_i,
  input  logic                addr_mode_i,
  input  logic                wake_set_i,
  input  logic [DLY_W-1:0]    delay_i,
  input  logic [CNT_W-1:0]    int_level_i,
  input  logic                int_en_i,
  input  logic                int_clr_i,
  output logic                tx_o,
  output logic                tx_ready_o,
  output logic                tx_empty_o,
  output logic [CNT_W-1:0]    fifo_cnt_o,
  output logic                int_flag_o,
  output logic                irq_o,
  output logic                wake_pend_o
);
  frame_cfg_t          cfg;
  logic [MAX_BITS-1:0] head;
  logic                pop, full, empty, busy;

  assign cfg = '{len_m1: char_len_i, par_en: parity_en_i, par_even: parity_even_i,
                 two_stop: two_stop_i, addr_mode: addr_mode_i};

  mptx_fifo #(.W(MAX_BITS), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk_i, .rst_ni, .clr_i(fifo_rst_i), .push_i(wr_en_i), .data_i(wr_data_i),
    .pop_i(pop), .data_o(head), .cnt_o(fifo_cnt_o), .full_o(full), .empty_o(empty)
  );

  mptx_serializer #(.GAP_BITS(GAP_BITS), .DLY_W(DLY_W)) u_ser (
    .clk_i, .rst_ni, .tick_i(bit_tick_i), .cfg_i(cfg), .delay_i,
    .avail_i(!empty), .data_i(head), .wake_i(wake_pend_o),
    .pop_o(pop), .tx_o, .busy_o(busy)
  );

  mptx_lvl_irq #(.CNT_W(CNT_W)) u_irq (
    .clk_i, .rst_ni, .cnt_i(fifo_cnt_o), .level_i(int_level_i),
    .en_i(int_en_i), .clr_i(int_clr_i), .flag_o(int_flag_o), .irq_o
  );

  // a new request wins over consumption in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wake_pend_o <= 1'b0;
    else if (wake_set_i) wake_pend_o <= 1'b1;
    else if (pop)        wake_pend_o <= 1'b0;
  end

  assign tx_ready_o = !full;
  assign tx_empty_o = empty && !busy;
endmodule

// File: rtl/mptx_checker.sv
module mptx_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_tick_i,
  input logic             fifo_rst_i,
  input logic             int_clr_i,
  input logic             tx_o,
  input logic             tx_empty_o,
  input logic [CNT_W-1:0] fifo_cnt_o,
  input logic             int_flag_o,
  input logic             irq_o
);
  a_r1_tick_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> $stable(tx_o));

  a_r11_empty_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> (tx_o && fifo_cnt_o == '0));

  a_r7_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_o <= CNT_W'(DEPTH));

  a_r7_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_rst_i |=> (fifo_cnt_o == $past(fifo_cnt_o) ||
                     fifo_cnt_o == $past(fifo_cnt_o) + CNT_W'(1) ||
                     fifo_cnt_o + CNT_W'(1) == $past(fifo_cnt_o)));

  a_r7_full_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt_o == CNT_W'(DEPTH) && !bit_tick_i && !fifo_rst_i) |=> fifo_cnt_o == CNT_W'(DEPTH));

  a_r8_fifo_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_i |=> fifo_cnt_o == '0);

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_clr_i |=> !int_flag_o);

  a_r9_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> int_flag_o);
endmodule

bind mptx_top mptx_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_tick_i(bit_tick_i), .fifo_rst_i(fifo_rst_i),
  .int_clr_i(int_clr_i), .tx_o(tx_o), .tx_empty_o(tx_empty_o),
  .fifo_cnt_o(fifo_cnt_o), .int_flag_o(int_flag_o), .irq_o(irq_o)
);

// File: tb/mptx_top_test.sv
module mptx_top_test;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       bit_tick = 1'b0;
  logic       wr_en, fifo_rst, parity_en, parity_even, two_stop, addr_mode, wake_set;
  logic       int_en, int_clr;
  logic [7:0] wr_data, delay;
  logic [2:0] char_len;
  logic [4:0] int_level;
  logic       tx, tx_ready, tx_empty, int_flag, irq, wake_pend;
  logic [4:0] fifo_cnt;

  int  errors = 0, checks = 0;
  bit  obs[$], exp_q[$];
  bit  rec = 1'b0;
  logic [7:0] wq[$];
  logic [4:0] ctr = '0;

  always #4 clk = ~clk;

  mptx_top uut (
    .clk_i(clk), .rst_ni, .bit_tick_i(bit_tick), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .fifo_rst_i(fifo_rst), .char_len_i(char_len), .parity_en_i(parity_en),
    .parity_even_i(parity_even), .two_stop_i(two_stop), .addr_mode_i(addr_mode),
    .wake_set_i(wake_set), .delay_i(delay), .int_level_i(int_level), .int_en_i(int_en),
    .int_clr_i(int_clr), .tx_o(tx), .tx_ready_o(tx_ready), .tx_empty_o(tx_empty),
    .fifo_cnt_o(fifo_cnt), .int_flag_o(int_flag), .irq_o(irq), .wake_pend_o(wake_pend)
  );

  // one tick per 32 cycles, line sampled mid-period
  always @(negedge clk) begin
    ctr      <= ctr + 5'd1;
    bit_tick <= (ctr == 5'd31);
    if (ctr == 5'd16 && rec) obs.push_back(tx);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic void add_frame(input logic [7:0] d, input bit wk);
    int ones = 0;
    if (!addr_mode && wk) repeat (11) exp_q.push_back(1'b1);
    exp_q.push_back(1'b0);
    for (int i = 0; i <= int'(char_len); i++) begin
      exp_q.push_back(d[i]);
      ones += int'(d[i]);
    end
    if (addr_mode) begin
      exp_q.push_back(wk);
      ones += int'(wk);
    end
    if (parity_en) exp_q.push_back(parity_even ? bit'(ones % 2) : bit'(1 - ones % 2));
    exp_q.push_back(1'b1);
    if (two_stop) exp_q.push_back(1'b1);
  endfunction

  task automatic start_scn(input int n, input bit wk);
    int m;
    exp_q.delete();
    obs.delete();
    m = (n > 16) ? 16 : n;
    for (int i = 0; i < m; i++) begin
      if (i > 0) repeat (int'(delay)) exp_q.push_back(1'b1);
      add_frame(wq[i], wk && i == 0);
    end
    while (ctr != 5'd2) @(negedge clk);
    if (wk) begin
      wake_set = 1'b1;
      @(negedge clk);
      wake_set = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1;
      wr_data = wq[i];
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk(tx_empty == 1'b0, "R11 busy after writes", tx_empty, 0);
    if (wk) chk(wake_pend == 1'b1, "R6 wake pending before load", wake_pend, 1);
    while (ctr != 5'd20 && ctr != 5'd21) @(negedge clk);
    rec = 1'b1;
  endtask

  task automatic finish_scn(input string tag);
    int bad = 0;
    while (obs.size() < exp_q.size()) @(negedge clk);
    rec = 1'b0;
    for (int i = 0; i < exp_q.size(); i++) if (obs[i] !== exp_q[i]) bad++;
    chk(bad == 0, tag, bad, 0);
    repeat (64) @(negedge clk);
    chk(tx_empty == 1'b1, "R11 empty after last frame", tx_empty, 1);
    chk(wake_pend == 1'b0, "R6 wake consumed", wake_pend, 0);
    repeat ((int'(delay) + 2) * 32) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; wr_en = 0; wr_data = 0; fifo_rst = 0; parity_en = 0; parity_even = 0;
    two_stop = 0; addr_mode = 0; wake_set = 0; int_en = 0; int_clr = 0;
    delay = 0; char_len = 3'd7; int_level = 5'd5;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    chk(tx == 1'b1, "R1 reset line high", tx, 1);
    chk(fifo_cnt == 0 && tx_ready == 1'b1, "R7 reset fifo empty and ready", fifo_cnt, 0);
    chk(tx_empty == 1'b1, "R11 reset empty", tx_empty, 1);
    chk(int_flag == 1'b0 && irq == 1'b0, "R9 reset flag clear", int_flag, 0);
    chk(wake_pend == 1'b0, "R6 reset no wake", wake_pend, 0);

    // back-to-back 8-bit frames
    wq = '{8'hA5, 8'h3C, 8'h01};
    start_scn(3, 0);
    finish_scn("R1 R10 back-to-back 8N1 stream");

    // 7 bits, even parity, two stops, delay 3
    char_len = 3'd6; parity_en = 1; parity_even = 1; two_stop = 1; delay = 8'd3;
    wq = '{8'h7F, 8'h55, 8'h80};
    start_scn(3, 0);
    finish_scn("R2 R3 R4 R10 7E2 delay 3 stream");

    // gap wake, odd parity
    char_len = 3'd4; parity_even = 0; two_stop = 0; delay = 8'd1;
    wq = '{8'h13, 8'h0E};
    start_scn(2, 1);
    finish_scn("R5 R3 idle-gap wake stream");

    // address marking
    addr_mode = 1; char_len = 3'd7; parity_en = 1; parity_even = 1; delay = 8'd0;
    wq = '{8'h42, 8'hFF, 8'h00};
    start_scn(3, 1);
    finish_scn("R6 R3 address-marked stream");
    addr_mode = 0; parity_en = 0;

    // long delay
    char_len = 3'd0; delay = 8'd40;
    wq = '{8'h01, 8'h00};
    start_scn(2, 0);
    finish_scn("R2 R10 one-bit chars delay 40");

    // full FIFO, overflow write, level interrupt
    char_len = 3'd7; delay = 8'd0; int_level = 5'd5; int_en = 0;
    wq.delete();
    for (int i = 0; i < 17; i++) wq.push_back(8'(i * 13 + 7));
    start_scn(17, 0);
    rec = 1'b0;
    chk(fifo_cnt == 5'd16, "R7 count saturates at 16", fifo_cnt, 16);
    chk(tx_ready == 1'b0, "R7 not ready when full", tx_ready, 0);
    chk(int_flag == 1'b1, "R9 flag set at level 5", int_flag, 1);
    chk(irq == 1'b0, "R9 irq gated off", irq, 0);
    int_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R9 irq enabled", irq, 1);
    int_clr = 1'b1;
    @(negedge clk);
    int_clr = 1'b0;
    chk(int_flag == 1'b0, "R9 write-one clear", int_flag, 0);
    rec = 1'b1;
    finish_scn("R7 first 16 bytes intact after overflow write");
    chk(int_flag == 1'b1, "R9 flag set again while draining", int_flag, 1);
    int_clr = 1'b1;
    @(negedge clk);
    int_clr = 1'b0;
    int_en = 1'b0;

    // FIFO reset discards queued bytes
    while (ctr != 5'd2) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      wr_en = 1'b1;
      wr_data = 8'h00;
      @(negedge clk);
    end
    wr_en = 1'b0;
    fifo_rst = 1'b1;
    @(negedge clk);
    fifo_rst = 1'b0;
    chk(fifo_cnt == 0 && tx_ready == 1'b1, "R8 reset empties fifo", fifo_cnt, 0);
    chk(tx_empty == 1'b1, "R8 empty after fifo reset", tx_empty, 1);
    exp_q.delete();
    obs.delete();
    repeat (4) exp_q.push_back(1'b1);
    rec = 1'b1;
    finish_scn("R8 discarded bytes not sent");

    // random formats
    for (int s = 0; s < 8; s++) begin
      int n;
      bit wk;
      char_len = 3'($urandom_range(0, 7));
      parity_en = 1'($urandom_range(0, 1));
      parity_even = 1'($urandom_range(0, 1));
      two_stop = 1'($urandom_range(0, 1));
      addr_mode = 1'($urandom_range(0, 1));
      delay = 8'($urandom_range(0, 4));
      n = int'($urandom_range(1, 5));
      wk = 1'($urandom_range(0, 1));
      wq.delete();
      for (int k = 0; k < n; k++) wq.push_back(8'($urandom_range(0, 255)));
      start_scn(n, wk);
      finish_scn("R1 R2 R3 R4 R5 R6 R10 random stream");
    end

    report();
  end
endmodule